// File: doc/BRIEF.md
# Debug Bus Match Comparator Channel

This block is one comparator channel of an on-chip debug unit. It watches the CPU data bus and raises an event for the debug state sequencer when a bus cycle hits a programmed address. The data value and the transfer direction can also take part in the hit. In tag mode the channel instead watches the instruction-fetch stream. A fetch from the programmed address marks that opcode, and the event fires only when the marked opcode leaves the instruction queue for execution. An opcode that is fetched and then discarded by a flush never fires.

A channel can also be set to end the debug session by itself, whatever state the sequencer is in. On a hit it then requests trace termination and disarms itself. It also raises a breakpoint request, but only while the global breakpoint enable is high. Once disarmed, the channel stays silent until it is armed again. Software loads the control word, the compare address and the compare data through three plain write ports.

Top module: `dbg_match_chan`

## Requirements
- R1: After reset the control word, compare address and compare data are all zero, the instruction-queue marks are cleared and the channel is armed. All five outputs stay low even when a valid bus cycle at address 0 with data 0 appears.
- R2: With control bit 0 (enable) at 0, none of `trig_now`, `trig_tag`, `end_trace`, `disarm` or `brk_req` is ever asserted.
- R3: With enable 1, tag bit 5 at 0 and the channel armed, `trig_now` is high in the same cycle as a `bus_valid` cycle whose address equals the compare address and whose data and direction qualify. It is low otherwise.
- R4: With control bit 2 (direction qualify) at 0, `bus_rd` plays no part in the match. With bit 2 at 1, control bit 3 selects the direction: 0 matches only writes (`bus_rd`=0) and 1 matches only reads (`bus_rd`=1).
- R5: With control bit 1 (data invert) at 0, the data part matches when `bus_data` equals the compare data. With bit 1 at 1, it matches when they differ. Bit 1 acts only when parameter `INV_DATA_OK` is 1, which is the default.
- R6: With tag bit 5 at 1, an `ex_adv` cycle with `fq_valid` high and `fq_addr` equal to the compare address marks the fetched opcode at the tail of a `QDEPTH`-entry queue (default 3). Each later `ex_adv` shifts the marks one slot toward execution. `trig_tag` is high in the `ex_adv` cycle in which the marked opcode executes, which is the QDEPTH-th `ex_adv` after the fetch. Fetches from any other address leave no mark.
- R7: `q_flush` clears every pending mark. `trig_tag` is low in a flush cycle, and opcodes marked before the flush never trigger.
- R8: With tag bit 5 at 1, `trig_now` stays low, and bits 1, 2 and 3 have no effect on marking.
- R9: With control bit 4 (break) at 1, any hit asserts `end_trace` and `disarm` in the same cycle. `brk_req` is asserted in that cycle only if `brk_glb_en` is 1.
- R10: With break bit 4 at 0, hits reach only `trig_now`/`trig_tag`, and `end_trace`, `disarm` and `brk_req` stay low.
- R11: After a `disarm` cycle the channel produces no output until `arm` is pulsed. `arm` takes effect from the following cycle, and a disarm in the same cycle as `arm` wins.
- R12: A value written on `cfg_we`, `addr_we` or `data_we` takes effect from the cycle after the write, and not in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_din | input | 6 | Control word: [0] enable, [1] data invert, [2] direction qualify, [3] direction (1=read), [4] break, [5] tag |
| addr_we | input | 1 | Compare address write strobe |
| addr_din | input | ADDR_W | Compare address value |
| data_we | input | 1 | Compare data write strobe |
| data_din | input | DATA_W | Compare data value |
| bus_valid | input | 1 | Bus cycle valid |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| fq_valid | input | 1 | The word entering the instruction queue is a real fetch |
| fq_addr | input | ADDR_W | Fetch address |
| ex_adv | input | 1 | Instruction queue advances; the head opcode executes |
| q_flush | input | 1 | Discard all queued opcodes |
| brk_glb_en | input | 1 | Global breakpoint enable |
| arm | input | 1 | Re-arm pulse |
| trig_now | output | 1 | Immediate bus match event |
| trig_tag | output | 1 | Marked opcode executed event |
| end_trace | output | 1 | Trace termination request |
| disarm | output | 1 | Disarm pulse |
| brk_req | output | 1 | Breakpoint request |

## Verification
The bench aims at the tag timing. A mark that fires one advance early or late, or one that survives a flush, shows up as a `trig_tag` pulse in the wrong cycle. It also checks that the direction and invert bits stay inert in tag mode. A design that let them gate marking would lose the tagged event. For break, the bench checks that `brk_req` follows the global enable and that the channel stays quiet after disarm until it is re-armed. A design that re-armed itself, or that let an arm win over a simultaneous disarm, would produce stray events. Writes are checked to take effect one cycle late. A write-through design would match during the write cycle itself.

// File: rtl/dbg_match_chan.sv
module dbg_match_chan #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 3,
  parameter bit INV_DATA_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_din,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_din,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_din,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              fq_valid,
  input  logic [ADDR_W-1:0] fq_addr,
  input  logic              ex_adv,
  input  logic              q_flush,
  input  logic              brk_glb_en,
  input  logic              arm,
  output logic              trig_now,
  output logic              trig_tag,
  output logic              end_trace,
  output logic              disarm,
  output logic              brk_req
);

  logic [5:0]        cfg;
  logic [ADDR_W-1:0] cmp_a;
  logic [DATA_W-1:0] cmp_d;
  logic              armed;
  logic [QDEPTH-1:0] tq;

  logic en, inv, rwq, rwv, brk, tag, live;
  assign en   = cfg[0];
  assign inv  = cfg[1] & INV_DATA_OK;
  assign rwq  = cfg[2];
  assign rwv  = cfg[3];
  assign brk  = cfg[4];
  assign tag  = cfg[5];
  assign live = en & armed;

  logic data_hit, dir_hit, mark;
  assign data_hit = (bus_data == cmp_d) ^ inv;
  assign dir_hit  = !rwq || (bus_rd == rwv);
  assign mark     = live & tag & fq_valid & (fq_addr == cmp_a);

  assign trig_now  = live & !tag & bus_valid & (bus_addr == cmp_a) & data_hit & dir_hit;
  assign trig_tag  = live & tag & ex_adv & !q_flush & tq[0];
  assign end_trace = (trig_now | trig_tag) & brk;
  assign disarm    = end_trace;
  assign brk_req   = end_trace & brk_glb_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      cmp_a <= '0;
      cmp_d <= '0;
    end else begin
      if (cfg_we)  cfg   <= cfg_din;
      if (addr_we) cmp_a <= addr_din;
      if (data_we) cmp_d <= data_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b1;
    else if (end_trace) armed <= 1'b0;
    else if (arm)       armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tq <= '0;
    else if (q_flush) tq <= '0;
    else if (ex_adv)  tq <= {mark, tq[QDEPTH-1:1]};
  end

  // R2
  enable_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(trig_now || trig_tag || end_trace || disarm || brk_req));

  // R8
  tag_blocks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag |-> !trig_now);

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> !trig_tag);

  // R9
  brk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_glb_en && end_trace && disarm));

  // R11
  disarm_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !(trig_now || trig_tag));

  // R10
  no_break_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk |-> !(end_trace || brk_req));

endmodule

// File: tb/dbg_match_chan_tb.sv
`timescale 1ns/1ps
module dbg_match_chan_tb_top;
  localparam int AW = 16, DW = 8, QD = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, addr_we = 0, data_we = 0;
  logic [5:0] cfg_din = 0;
  logic [AW-1:0] addr_din = 0, bus_addr = 0, fq_addr = 0;
  logic [DW-1:0] data_din = 0, bus_data = 0;
  logic bus_valid = 0, bus_rd = 0, fq_valid = 0, ex_adv = 0, q_flush = 0;
  logic brk_glb_en = 0, arm = 0;
  logic trig_now, trig_tag, end_trace, disarm, brk_req;

  always #2 clk = ~clk;

  dbg_match_chan #(.ADDR_W(AW), .DATA_W(DW), .QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .addr_we(addr_we), .addr_din(addr_din), .data_we(data_we), .data_din(data_din),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd),
    .fq_valid(fq_valid), .fq_addr(fq_addr), .ex_adv(ex_adv), .q_flush(q_flush),
    .brk_glb_en(brk_glb_en), .arm(arm), .trig_now(trig_now), .trig_tag(trig_tag),
    .end_trace(end_trace), .disarm(disarm), .brk_req(brk_req));

  int vectors = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int c_now, c_tag, c_end, c_brk;

  logic [5:0] m_cfg;
  logic [AW-1:0] m_a;
  logic [DW-1:0] m_d;
  bit m_armed;
  bit m_q[$];

  task automatic model_reset();
    m_cfg = 0; m_a = 0; m_d = 0; m_armed = 1;
    m_q = {};
    for (int i = 0; i < QD; i++) m_q.push_back(1'b0);
  endtask

  task automatic chk(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clr();
    c_now = 0; c_tag = 0; c_end = 0; c_brk = 0;
  endtask

  task automatic tick();
    bit en, inv, rwq, rwv, brk, tag, live, e_now, e_tag, e_end, newmark;
    logic [4:0] got, exp;
    #1;
    en = m_cfg[0]; inv = m_cfg[1]; rwq = m_cfg[2]; rwv = m_cfg[3];
    brk = m_cfg[4]; tag = m_cfg[5]; live = en && m_armed;
    e_now = live && !tag && bus_valid && (bus_addr == m_a) &&
            ((bus_data == m_d) != inv) && (!rwq || (bus_rd == rwv));
    e_tag = live && tag && ex_adv && !q_flush && m_q[0];
    e_end = (e_now || e_tag) && brk;
    newmark = live && tag && fq_valid && (fq_addr == m_a);
    exp = {e_now, e_tag, e_end, e_end, e_end && brk_glb_en};
    got = {trig_now, trig_tag, end_trace, disarm, brk_req};
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: outputs now/tag/end/dis/brk got %b expected %b", cur_req, got, exp);
    end
    c_now += int'(trig_now); c_tag += int'(trig_tag);
    c_end += int'(end_trace); c_brk += int'(brk_req);
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (cfg_we) m_cfg = cfg_din;
      if (addr_we) m_a = addr_din;
      if (data_we) m_d = data_din;
      if (e_end) m_armed = 0; else if (arm) m_armed = 1;
      if (q_flush) begin
        m_q = {};
        for (int i = 0; i < QD; i++) m_q.push_back(1'b0);
      end else if (ex_adv) begin
        void'(m_q.pop_front());
        m_q.push_back(newmark);
      end
    end
    @(negedge clk);
  endtask

  task automatic load(logic [5:0] c, logic [AW-1:0] a, logic [DW-1:0] d);
    cfg_we = 1; cfg_din = c; addr_we = 1; addr_din = a; data_we = 1; data_din = d;
    tick();
    cfg_we = 0; addr_we = 0; data_we = 0;
  endtask

  task automatic bus(logic [AW-1:0] a, logic [DW-1:0] d, logic rd);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_rd = rd;
    tick();
    bus_valid = 0;
  endtask

  task automatic adv(logic fv, logic [AW-1:0] fa);
    ex_adv = 1; fq_valid = fv; fq_addr = fa;
    tick();
    ex_adv = 0; fq_valid = 0;
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    // R1 reset state
    cur_req = "R1"; clr();
    bus_valid = 1; bus_addr = 0; bus_data = 0;
    tick(); tick();
    rst_n = 1;
    tick(); tick();
    bus_valid = 0;
    chk("R1", c_now + c_tag + c_end, 0);

    // R2 enable off
    cur_req = "R2"; clr();
    load(6'h3E, 16'h1234, 8'h5A);
    load(6'h1E, 16'h1234, 8'h5A);
    bus(16'h1234, 8'h5A, 1); bus(16'h1234, 8'h5B, 0);
    chk("R2", c_now + c_end + c_brk, 0);

    // R12 write takes effect next cycle
    cur_req = "R12"; clr();
    cfg_we = 1; cfg_din = 6'h01;
    bus_valid = 1; bus_addr = 16'h1234; bus_data = 8'h5A; bus_rd = 0;
    tick();
    chk("R12 write cycle", c_now, 0);
    cfg_we = 0;
    tick();
    bus_valid = 0;
    chk("R12 next cycle", c_now, 1);

    // R3 immediate match
    cur_req = "R3"; clr();
    bus(16'h1234, 8'h5A, 1);
    bus(16'h1235, 8'h5A, 1);
    bus(16'h1234, 8'h5B, 1);
    bus_addr = 16'h1234; bus_data = 8'h5A; tick();
    chk("R3", c_now, 1);

    // R4 direction qualification
    cur_req = "R4"; clr();
    bus(16'h1234, 8'h5A, 0); bus(16'h1234, 8'h5A, 1);
    chk("R4 unqualified", c_now, 2); clr();
    load(6'h05, 16'h1234, 8'h5A);
    bus(16'h1234, 8'h5A, 0); bus(16'h1234, 8'h5A, 1);
    chk("R4 write only", c_now, 1); clr();
    load(6'h0D, 16'h1234, 8'h5A);
    bus(16'h1234, 8'h5A, 1); bus(16'h1234, 8'h5A, 0);
    chk("R4 read only", c_now, 1);

    // R5 data invert
    cur_req = "R5"; clr();
    load(6'h03, 16'h1234, 8'h5A);
    bus(16'h1234, 8'h5A, 0); bus(16'h1234, 8'hA5, 0); bus(16'h1234, 8'h00, 1);
    chk("R5", c_now, 2);

    // R6 tagged opcode timing
    cur_req = "R6"; clr();
    load(6'h21, 16'h4000, 8'h00);
    adv(1, 16'h4000);
    adv(1, 16'h4002);
    tick();
    adv(0, 0);
    chk("R6 not early", c_tag, 0);
    adv(0, 0);
    chk("R6 third advance", c_tag, 1);
    adv(0, 0); adv(0, 0); adv(0, 0);
    chk("R6 single pulse", c_tag, 1);

    // R8 tag mode ignores qualifiers and bus path
    cur_req = "R8"; clr();
    load(6'h2F, 16'h4000, 8'h77);
    bus(16'h4000, 8'h77, 1); bus(16'h4000, 8'h12, 0);
    adv(1, 16'h4000); adv(0, 0); adv(0, 0); adv(0, 0);
    chk("R8 no bus trigger", c_now, 0);
    chk("R8 mark kept", c_tag, 1);

    // R7 flush
    cur_req = "R7"; clr();
    adv(1, 16'h4000); adv(1, 16'h4000);
    q_flush = 1; ex_adv = 1; tick(); q_flush = 0; ex_adv = 0;
    adv(0, 0); adv(0, 0); adv(0, 0); adv(0, 0);
    chk("R7", c_tag, 0);

    // R9 break without global enable, R11 disarm
    cur_req = "R9"; clr();
    load(6'h11, 16'h2000, 8'h33);
    brk_glb_en = 0;
    bus(16'h2000, 8'h33, 0);
    chk("R9 end", c_end, 1);
    chk("R9 no brk", c_brk, 0);
    cur_req = "R11"; clr();
    bus(16'h2000, 8'h33, 0); bus(16'h2000, 8'h33, 1);
    chk("R11 silent", c_now + c_end, 0);
    arm = 1; bus(16'h2000, 8'h33, 0); arm = 0;
    chk("R11 arm cycle", c_now, 0);
    cur_req = "R9"; clr();
    brk_glb_en = 1;
    bus(16'h2000, 8'h33, 0);
    chk("R9 brk", c_brk, 1);
    // R11 disarm beats simultaneous arm
    cur_req = "R11"; clr();
    arm = 1; tick(); arm = 0;
    bus_valid = 1; bus_addr = 16'h2000; bus_data = 8'h33; arm = 1; tick();
    arm = 0; bus_valid = 0;
    bus(16'h2000, 8'h33, 0);
    chk("R11 disarm wins", c_end, 1);
    arm = 1; tick(); arm = 0;
    // R9 tag plus break
    cur_req = "R9"; clr();
    load(6'h31, 16'h2000, 8'h00);
    adv(1, 16'h2000); adv(0, 0); adv(0, 0); adv(0, 0);
    chk("R9 tag break", c_brk, 1);
    arm = 1; tick(); arm = 0;

    // R10 no break
    cur_req = "R10"; clr();
    load(6'h01, 16'h2000, 8'h33);
    bus(16'h2000, 8'h33, 0); bus(16'h2000, 8'h33, 1);
    chk("R10 hits", c_now, 2);
    chk("R10 no end", c_end + c_brk, 0);

    // Mixed random traffic, model compared every cycle
    cur_req = "R3/R4/R5/R6/R7/R9/R11 mixed";
    for (int i = 0; i < 3000; i++) begin
      cfg_we = ($urandom_range(0, 15) == 0);
      cfg_din = 6'($urandom) | 6'h01;
      addr_we = 0; data_we = 0;
      bus_valid = 1'($urandom);
      bus_addr = $urandom_range(0, 1) ? 16'h2000 : 16'h2001;
      bus_data = $urandom_range(0, 1) ? 8'h33 : 8'h32;
      bus_rd = 1'($urandom);
      ex_adv = 1'($urandom);
      fq_valid = 1'($urandom);
      fq_addr = $urandom_range(0, 1) ? 16'h2000 : 16'h2004;
      q_flush = ($urandom_range(0, 19) == 0);
      arm = ($urandom_range(0, 7) == 0);
      brk_glb_en = 1'($urandom);
      tick();
    end
    cfg_we = 0; bus_valid = 0; ex_adv = 0; fq_valid = 0; q_flush = 0; arm = 0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule